// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block decides how many clock states a single bus access lasts. An access request arrives with an address area (0 to 7), a read/write flag, a space type and a refresh flag. From these and a control register, the block works out two things. The first is a base number of states. The second is whether the external WAIT input is sampled at the end of the last base state. It then holds a cycle-active signal for that many clocks. Each clock in which WAIT is found asserted adds one state. A one-clock completion strobe marks the final state.

The control register holds several fields:
- one WAIT-sampling bit per area;
- a column-pitch bit for DRAM writes;
- a 2-bit long-wait field, used by areas 0, 2 and 6;
- a 2-bit long-wait field for refresh cycles.

Its unused bits read back as ones. The register and the space type are captured when the access is accepted. A register write or a new request during a running cycle therefore does not change that cycle.

Top module: `bws_wait_sequencer`

## Requirements
- R1: After reset the block is idle (`busy_o` and `done_o` low) and `cfg_rdata_o` reads 16'hFFFF.
- R2: The register layout is: bits [7:0] are the per-area WAIT-sampling bits (bit n for area n), bit 8 is the DRAM write column-pitch bit, bits [11:10] are the area long-wait field, and bits [13:12] are the refresh long-wait field. Bits 9, 14 and 15 always read 1, so a write of value d reads back as d | 16'hC200.
- R3: The `space_i` codes are 0 external, 1 DRAM column phase, 2 multiplexed I/O, 3 on-chip peripheral and 4 on-chip memory. Codes 5 to 7 behave as code 4. An on-chip peripheral access lasts exactly 3 states and an on-chip memory access exactly 1 state, whatever WAIT does.
- R4: A multiplexed I/O access lasts 4 states plus one per sampled-asserted WAIT, even when the area's sampling bit is 0.
- R5: An external read of area 1, 3, 4, 5 or 7 lasts exactly 1 state with WAIT ignored when the area's bit is 0. When the bit is 1 it lasts 2 states plus the WAIT states.
- R6: An external read of area 0, 2 or 6 lasts 1 + (L+1) states, where L is the long-wait field. WAIT states are added on top only when the area's bit is 1.
- R7: For a DRAM column phase, the pitch bit is the area-1 sampling bit on reads and bit 8 on writes. A pitch bit of 0 gives exactly 1 state. A pitch bit of 1 gives 2 states plus the WAIT states.
- R8: An external write to area 1 lasts 2 states plus the WAIT states, regardless of bit 1. External writes to other areas follow the read rules of R5 and R6.
- R9: With `cbr_i` high the access lasts 1 + (F+1) states for any space, where F is the refresh long-wait field, and WAIT is ignored.
- R10: WAIT is sampled in the last base state. Each clock in which it is found asserted adds one state. `done_o` is high for exactly one clock, the final busy clock, and `busy_o` is low on the next clock.
- R11: A request while busy is ignored. A register write during a cycle changes neither that cycle's length nor its WAIT sampling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, accepted when idle |
| area_i | input | 3 | Address area of the access |
| wr_i | input | 1 | 1 = write, 0 = read |
| space_i | input | 3 | Space type code (see R3) |
| cbr_i | input | 1 | Refresh cycle flag |
| wait_i | input | 1 | External WAIT, active high |
| cfg_we_i | input | 1 | Control register write enable |
| cfg_wdata_i | input | 16 | Control register write data |
| cfg_rdata_o | output | 16 | Control register read value |
| busy_o | output | 1 | High during every state of a cycle |
| done_o | output | 1 | One-clock strobe in the final state |

## Verification
Some rules are checked by the assertions on every clock:
- the strobe falls only inside a busy cycle and ends it;
- a cycle stretches past its last base state only when WAIT was sampled asserted with sampling enabled;
- the captured sampling decision stays stable for the whole cycle;
- refresh, on-chip and multiplexed I/O accesses get the sampling decision their rules demand;
- the reserved register bits stay at one.

Other behaviour only the bench scenarios can show:
- the exact state counts per area group, pitch, long-wait value and WAIT pattern;
- that a register write or a second request in mid-cycle leaves the running cycle untouched.

// File: rtl/bws_pkg.sv
package bws_pkg;

  localparam int AREA_N = 8;
  localparam int AREA_W = $clog2(AREA_N);
  localparam int LW_W   = 2;
  localparam int CNT_W  = 3;
  localparam int REG_W  = 16;

  localparam logic [2:0] SP_EXT    = 3'd0;
  localparam logic [2:0] SP_DCOL   = 3'd1;
  localparam logic [2:0] SP_MUXIO  = 3'd2;
  localparam logic [2:0] SP_PERIPH = 3'd3;
  localparam logic [2:0] SP_ONCHIP = 3'd4;

  localparam logic [REG_W-1:0] RSVD_ONES = 16'hC200;

  typedef struct packed {
    logic [AREA_N-1:0] smp;
    logic              wr_pitch;
    logic [LW_W-1:0]   lw;
    logic [LW_W-1:0]   ref_lw;
  } cfg_t;

  function automatic logic long_group(input logic [AREA_W-1:0] area);
    return (area == 3'd0) || (area == 3'd2) || (area == 3'd6);
  endfunction

  function automatic logic dram_pitch(input cfg_t cfg, input logic wr);
    return wr ? cfg.wr_pitch : cfg.smp[1];
  endfunction

  function automatic logic [CNT_W-1:0] lw_states(input logic [LW_W-1:0] f);
    return CNT_W'(2) + CNT_W'(f);
  endfunction

  function automatic logic [CNT_W-1:0] base_states(
      input cfg_t              cfg,
      input logic [AREA_W-1:0] area,
      input logic              wr,
      input logic [2:0]        space,
      input logic              cbr);
    logic [CNT_W-1:0] n;
    if (cbr) begin
      n = lw_states(cfg.ref_lw);
    end else begin
      case (space)
        SP_DCOL:   n = dram_pitch(cfg, wr) ? CNT_W'(2) : CNT_W'(1);
        SP_MUXIO:  n = CNT_W'(4);
        SP_PERIPH: n = CNT_W'(3);
        SP_EXT: begin
          if (long_group(area))          n = lw_states(cfg.lw);
          else if (wr && area == 3'd1)   n = CNT_W'(2);
          else if (cfg.smp[area])        n = CNT_W'(2);
          else                           n = CNT_W'(1);
        end
        default:   n = CNT_W'(1);
      endcase
    end
    return n;
  endfunction

  function automatic logic wait_sampled(
      input cfg_t              cfg,
      input logic [AREA_W-1:0] area,
      input logic              wr,
      input logic [2:0]        space,
      input logic              cbr);
    logic s;
    if (cbr) begin
      s = 1'b0;
    end else begin
      case (space)
        SP_DCOL:  s = dram_pitch(cfg, wr);
        SP_MUXIO: s = 1'b1;
        SP_EXT:   s = (wr && area == 3'd1) ? 1'b1 : cfg.smp[area];
        default:  s = 1'b0;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/bws_cfg_reg.sv
module bws_cfg_reg
  import bws_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output cfg_t             cfg_o,
  output logic [REG_W-1:0] rdata_o
);

  cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.smp      <= '1;
      cfg_q.wr_pitch <= 1'b1;
      cfg_q.lw       <= '1;
      cfg_q.ref_lw   <= '1;
    end else if (we_i) begin
      cfg_q.smp      <= wdata_i[7:0];
      cfg_q.wr_pitch <= wdata_i[8];
      cfg_q.lw       <= wdata_i[11:10];
      cfg_q.ref_lw   <= wdata_i[13:12];
    end
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {2'b11, cfg_q.ref_lw, cfg_q.lw, 1'b1, cfg_q.wr_pitch, cfg_q.smp};

  AST_RSVD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o & RSVD_ONES) == RSVD_ONES) else $error("reserved bits not one"); // R2

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> rdata_o == ($past(wdata_i) | RSVD_ONES)) else $error("write not visible"); // R2

endmodule

// File: rtl/bws_timing_decode.sv
module bws_timing_decode
  import bws_pkg::*;
(
  input  cfg_t              cfg_i,
  input  logic [AREA_W-1:0] area_i,
  input  logic              wr_i,
  input  logic [2:0]        space_i,
  input  logic              cbr_i,
  output logic [CNT_W-1:0]  base_o,
  output logic              smp_o
);

  always_comb begin
    base_o = base_states(cfg_i, area_i, wr_i, space_i, cbr_i);
    smp_o  = wait_sampled(cfg_i, area_i, wr_i, space_i, cbr_i);
  end

endmodule

// File: rtl/bws_cycle_seq.sv
module bws_cycle_seq
  import bws_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [CNT_W-1:0] base_i,
  input  logic             smp_i,
  input  logic             wait_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o
);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             smp_q;
  logic             term;
  logic             ext_wait;

  assign accept_o = req_i && !busy_q;
  assign term     = busy_q && (cnt_q == CNT_W'(1));
  assign ext_wait = term && smp_q && wait_i;
  assign done_o   = term && !ext_wait;
  assign busy_o   = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      smp_q  <= 1'b0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= base_i;
      smp_q  <= smp_i;
    end else if (busy_q) begin
      if (cnt_q > CNT_W'(1)) cnt_q <= cnt_q - CNT_W'(1);
      else if (!ext_wait)    busy_q <= 1'b0;
    end
  end

  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o) else $error("strobe outside cycle"); // R10

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o) else $error("cycle continued after strobe"); // R10

  AST_WAIT_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && cnt_q == CNT_W'(1) && $past(cnt_q) == CNT_W'(1))
      |-> $past(smp_q && wait_i)) else $error("stretch without sampled WAIT"); // R10

  AST_CAPTURE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(smp_q)) else $error("sampling changed mid-cycle"); // R11

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - CNT_W'(1)) else $error("count disturbed"); // R11

endmodule

// File: rtl/bws_wait_sequencer.sv
module bws_wait_sequencer
  import bws_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic [2:0]  area_i,
  input  logic        wr_i,
  input  logic [2:0]  space_i,
  input  logic        cbr_i,
  input  logic        wait_i,
  input  logic        cfg_we_i,
  input  logic [15:0] cfg_wdata_i,
  output logic [15:0] cfg_rdata_o,
  output logic        busy_o,
  output logic        done_o
);

  cfg_t             cfg;
  logic [CNT_W-1:0] base_states_w;
  logic             smp_w;
  logic             accept_w;

  bws_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o)
  );

  bws_timing_decode u_dec (
    .cfg_i   (cfg),
    .area_i  (area_i),
    .wr_i    (wr_i),
    .space_i (space_i),
    .cbr_i   (cbr_i),
    .base_o  (base_states_w),
    .smp_o   (smp_w)
  );

  bws_cycle_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .base_i   (base_states_w),
    .smp_i    (smp_w),
    .wait_i   (wait_i),
    .accept_o (accept_w),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  AST_FIXED_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cbr_i && (space_i == SP_PERIPH || space_i >= SP_ONCHIP)) |-> !smp_w) else $error("on-chip sampled WAIT"); // R3

  AST_MUXIO_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cbr_i && space_i == SP_MUXIO) |-> (smp_w && base_states_w == CNT_W'(4))) else $error("mux I/O timing"); // R4

  AST_CBR_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_i |-> (!smp_w && base_states_w >= CNT_W'(2))) else $error("refresh sampled WAIT"); // R9

  AST_LONG_GROUP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cbr_i && space_i == SP_EXT && long_group(area_i)) |-> base_states_w >= CNT_W'(2)) else $error("long wait missing"); // R6

  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |-> !busy_o) else $error("accepted while busy"); // R11

endmodule

// File: tb/bws_wait_sequencer_tb.sv
module bws_wait_sequencer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [2:0]  area_i = '0;
  logic        wr_i = 1'b0;
  logic [2:0]  space_i = '0;
  logic        cbr_i = 1'b0;
  logic        wait_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_rdata_o;
  logic        busy_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] shadow = 16'hFFFF;

  always #4 clk = ~clk;

  bws_wait_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .area_i(area_i), .wr_i(wr_i),
    .space_i(space_i), .cbr_i(cbr_i), .wait_i(wait_i), .cfg_we_i(cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected timing restated from the requirements
  function automatic int exp_base(input logic [15:0] c, input int area, input bit wr,
                                  input int sp, input bit cbr);
    bit pitch;
    if (cbr) return 2 + int'(c[13:12]);
    pitch = wr ? c[8] : c[1];
    if (sp == 1) return pitch ? 2 : 1;
    if (sp == 2) return 4;
    if (sp == 3) return 3;
    if (sp != 0) return 1;
    if (area inside {0, 2, 6}) return 2 + int'(c[11:10]);
    if (wr && area == 1) return 2;
    return c[area] ? 2 : 1;
  endfunction

  function automatic bit exp_smp(input logic [15:0] c, input int area, input bit wr,
                                 input int sp, input bit cbr);
    if (cbr) return 1'b0;
    if (sp == 1) return wr ? c[8] : c[1];
    if (sp == 2) return 1'b1;
    if (sp != 0) return 1'b0;
    if (wr && area == 1) return 1'b1;
    return c[area];
  endfunction

  task automatic cfg_write(input logic [15:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
    shadow = d | 16'hC200;
  endtask

  task automatic run_access(input int area, input bit wr, input int sp, input bit cbr,
                            input int k, input bit disturb, input string tag);
    int b, expn, len;
    bit s;
    b = exp_base(shadow, area, wr, sp, cbr);
    s = exp_smp(shadow, area, wr, sp, cbr);
    expn = b + (s ? k : 0);
    len = -1;
    @(negedge clk);
    req_i = 1'b1; area_i = 3'(area); wr_i = wr; space_i = 3'(sp); cbr_i = cbr;
    @(negedge clk);
    req_i = 1'b0;
    for (int idx = 0; idx < 30; idx++) begin
      if (s) wait_i = (idx >= b - 1) && (idx < b - 1 + k);
      else   wait_i = 1'($urandom_range(0, 1));
      if (disturb && idx == 0) begin
        req_i = 1'b1; space_i = 3'd3; area_i = 3'd0; cfg_we_i = 1'b1; cfg_wdata_i = 16'h0000;
      end else if (disturb && idx == 1) begin
        req_i = 1'b0; cfg_we_i = 1'b0;
        shadow = 16'hC200;
      end
      #1;
      if (!busy_o) begin len = -2; break; end
      if (done_o) begin len = idx + 1; break; end
      @(negedge clk);
    end
    if (disturb) begin req_i = 1'b0; cfg_we_i = 1'b0; shadow = 16'hC200; end
    wait_i = 1'b0;
    check(len == expn, tag, len, expn);
    @(negedge clk);
    check(busy_o == 1'b0, "R10 idle after strobe", busy_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(busy_o == 0 && done_o == 0, "R1 idle after reset", busy_o, 0);
    check(cfg_rdata_o == 16'hFFFF, "R1 reset register", cfg_rdata_o, 16'hFFFF);
    rst_n = 1'b1;

    // R2 register layout and reserved bits
    cfg_write(16'h0000);
    #1 check(cfg_rdata_o == 16'hC200, "R2 reserved ones", cfg_rdata_o, 16'hC200);
    cfg_write(16'h1234);
    #1 check(cfg_rdata_o == 16'hD234, "R2 readback", cfg_rdata_o, 16'hD234);
    cfg_write(16'hFFFF);

    // R3 on-chip spaces
    run_access(2, 0, 4, 0, 2, 0, "R3 on-chip memory");
    run_access(5, 1, 3, 0, 2, 0, "R3 peripheral");
    run_access(7, 0, 6, 0, 3, 0, "R3 code 6 as memory");

    // R4 multiplexed I/O
    run_access(3, 0, 2, 0, 0, 0, "R4 mux io no wait");
    cfg_write(16'h3C00);
    run_access(3, 1, 2, 0, 3, 0, "R4 mux io wait with bit clear");

    // R5 short-group external reads
    cfg_write(16'hFFFF);
    run_access(3, 0, 0, 0, 0, 0, "R5 area3 bit set");
    run_access(4, 0, 0, 0, 2, 0, "R5 area4 bit set wait");
    cfg_write(16'hFFF7);
    run_access(3, 0, 0, 0, 2, 0, "R5 area3 bit clear");

    // R6 long-group reads
    cfg_write(16'hFFFF);
    run_access(0, 0, 0, 0, 1, 0, "R6 area0 lw3 wait");
    cfg_write(16'hF3BF);
    run_access(6, 0, 0, 0, 2, 0, "R6 area6 lw0 bit clear");

    // R7 DRAM column pitch
    cfg_write(16'hFFFF);
    run_access(1, 0, 1, 0, 2, 0, "R7 read long pitch");
    run_access(1, 1, 1, 0, 1, 0, "R7 write long pitch");
    cfg_write(16'hFEFD);
    run_access(1, 0, 1, 0, 2, 0, "R7 read short pitch");
    run_access(1, 1, 1, 0, 2, 0, "R7 write short pitch");

    // R8 external writes
    run_access(1, 1, 0, 0, 2, 0, "R8 area1 write");
    run_access(2, 1, 0, 0, 0, 0, "R8 area2 write");

    // R9 refresh
    cfg_write(16'hEFFF);
    run_access(0, 0, 2, 1, 3, 0, "R9 refresh");

    // R11 disturbance during a cycle
    cfg_write(16'hFFFF);
    run_access(3, 0, 0, 0, 1, 1, "R11 mid-cycle write and request");
    run_access(3, 0, 0, 0, 2, 0, "R11 new config takes effect");

    // random mix, R10 length and strobe on every access
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 4) == 0) cfg_write(16'($urandom()));
      run_access(int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, 7)), ($urandom_range(0, 5) == 0),
                 int'($urandom_range(0, 3)), 0, "R10 random access");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule